// File: doc/BRIEF.md
# Hamming Syndrome Checker

This block decides whether a 256-byte flash chunk read back intact. It compares two single-error-correcting Hamming codes: the one kept in the spare area and the one recomputed while the chunk streamed in. Each code holds eleven line and column parity bits followed by their eleven complements, 22 meaningful bits in all.

The block XORs the two codes into a syndrome and sorts the result into one of four classes. A correctable result also gives the byte index and bit position that a downstream patch stage has to invert. The patch stage and the data buffer sit outside this block.

A pulse on the start input samples both code buses. One clock later the block registers its verdict and raises a one-cycle done strobe. The result then holds until the next start. With the dual-chunk input set, the block checks a second code pair for the next 256 bytes in the same operation and merges the two outcomes.

Top module: `ecc_syndrome_checker`

## Requirements
- R1: A high `start_i` at a rising edge makes `done_o` high for the following cycle, and the registered results change in that same cycle. `done_o` is low in every cycle not preceded by a start. After reset all outputs are zero.
- R2: Between start pulses every result output keeps its value, even when the code inputs change.
- R3: A chunk is clean (class 0, no error, no fix) in three cases: the low 22 bits of its syndrome are zero, the low 22 bits of the stored code are zero, or the low 22 bits of the computed code are zero.
- R4: A syndrome with exactly one bit set classifies as a corrupt code field (class 1). It raises the error flag and gives no fix.
- R5: A syndrome is correctable (class 2, no error, fix valid) when it has exactly eleven set bits and its low 11 bits XOR its high 11 bits equals 0x7FF. The fix bit is syndrome[2:0] and the fix byte is syndrome[10:3].
- R6: Any other non-clean syndrome is uncorrectable (class 3) and raises the error flag.
- R7: Bits 23:22 of each 24-bit code have no effect on the result.
- R8: Each code is little-endian: code byte 0 sits at bus bits [7:0]. Chunk 0 uses bytes 0 to 2 (bits [23:0]) and chunk 1 uses bytes 3 to 5 (bits [47:24]). Chunk k reports its class on `status_o[2k+1:2k]`, its fix byte on `fix_byte_o[9k+8:9k]` and its fix bit on `fix_bit_o[3k+2:3k]`.
- R9: With `dual_i` high, chunk 1 is checked and its fix byte carries an offset of 256. With `dual_i` low, chunk 1 reports clean with no fix, whatever its codes hold.
- R10: `err_o` is high exactly when at least one chunk is in class 1 or class 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample the codes and evaluate |
| dual_i | input | 1 | Also check chunk 1 (512-byte mode) |
| stored_ecc_i | input | 48 | Codes read from flash, byte 0 in bits [7:0] |
| calc_ecc_i | input | 48 | Codes computed on read, same layout |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Merged uncorrectable or corrupt-field flag |
| status_o | output | 4 | Class per chunk: 0 clean, 1 code field, 2 correctable, 3 uncorrectable |
| fix_valid_o | output | 2 | Per-chunk fix location valid |
| fix_byte_o | output | 18 | Per-chunk byte index to patch, 9 bits each |
| fix_bit_o | output | 6 | Per-chunk bit position to patch, 3 bits each |

## Verification
Two functions can fall in the same evaluation: a correctable result in one chunk and a fatal result in the other. The test provokes this with a single dual-chunk start. It then checks that the fix location for the clean-up chunk is still given and carries the right offset, while the merged flag reports the other chunk. A new start can also land in the cycle where the previous result is being strobed out. The test holds start high for two edges with different codes, then checks that the strobe stays high and that each cycle shows its own verdict.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

  typedef enum logic [1:0] {
    CLS_CLEAN     = 2'd0,
    CLS_ECC_FIELD = 2'd1,
    CLS_FIXABLE   = 2'd2,
    CLS_FATAL     = 2'd3
  } ecc_cls_e;

  function automatic logic cls_is_err(input ecc_cls_e c);
    return (c == CLS_ECC_FIELD) || (c == CLS_FATAL);
  endfunction

endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter  int W  = 22,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end

endmodule

// File: rtl/ecc_chunk_classify.sv
module ecc_chunk_classify
  import ecc_chk_pkg::*;
#(
  parameter  int PARITY_W   = 11,
  parameter  int CODE_BYTES = 3,
  localparam int CODE_W     = 2 * PARITY_W,
  localparam int RAW_W      = CODE_BYTES * 8,
  localparam int PC_W       = $clog2(CODE_W + 1)
) (
  input  logic [RAW_W-1:0]    stored_i,
  input  logic [RAW_W-1:0]    calc_i,
  output ecc_cls_e            cls_o,
  output logic [PARITY_W-1:0] loc_o
);

  logic [CODE_W-1:0]   syn;
  logic [PARITY_W-1:0] syn_lo, syn_hi;
  logic [PC_W-1:0]     ones;
  logic                any_zero;

  assign syn      = stored_i[CODE_W-1:0] ^ calc_i[CODE_W-1:0];
  assign syn_lo   = syn[PARITY_W-1:0];
  assign syn_hi   = syn[CODE_W-1:PARITY_W];
  assign any_zero = (stored_i[CODE_W-1:0] == '0) || (calc_i[CODE_W-1:0] == '0);

  // pad bits above the parity field carry nothing
  generate
    if (RAW_W > CODE_W) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^{stored_i[RAW_W-1:CODE_W], calc_i[RAW_W-1:CODE_W]};
    end
  endgenerate

  ecc_popcount #(.W(CODE_W)) i_pop (
    .vec_i (syn),
    .cnt_o (ones)
  );

  always_comb begin
    if (syn == '0 || any_zero)                                   cls_o = CLS_CLEAN;
    else if (ones == PC_W'(1))                                   cls_o = CLS_ECC_FIELD;
    else if (ones == PC_W'(PARITY_W) && (syn_lo ^ syn_hi) == '1) cls_o = CLS_FIXABLE;
    else                                                         cls_o = CLS_FATAL;
  end

  assign loc_o = syn_lo;

endmodule

// File: rtl/ecc_syndrome_checker.sv
module ecc_syndrome_checker
  import ecc_chk_pkg::*;
#(
  parameter  int PARITY_W    = 11,
  parameter  int CODE_BYTES  = 3,
  parameter  int CHUNK_BYTES = 256,
  parameter  int NUM_CHUNKS  = 2,
  localparam int RAW_W       = CODE_BYTES * 8,
  localparam int BUS_W       = NUM_CHUNKS * RAW_W,
  localparam int BIT_W       = 3,
  localparam int OFS_W       = $clog2(NUM_CHUNKS * CHUNK_BYTES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        dual_i,
  input  logic [BUS_W-1:0]            stored_ecc_i,
  input  logic [BUS_W-1:0]            calc_ecc_i,
  output logic                        done_o,
  output logic                        err_o,
  output logic [2*NUM_CHUNKS-1:0]     status_o,
  output logic [NUM_CHUNKS-1:0]       fix_valid_o,
  output logic [NUM_CHUNKS*OFS_W-1:0] fix_byte_o,
  output logic [NUM_CHUNKS*BIT_W-1:0] fix_bit_o
);

  ecc_cls_e            cls_w [NUM_CHUNKS];
  logic [PARITY_W-1:0] loc_w [NUM_CHUNKS];
  ecc_cls_e            eff_w [NUM_CHUNKS];

  logic [2*NUM_CHUNKS-1:0]     status_d;
  logic [NUM_CHUNKS-1:0]       fixv_d;
  logic [NUM_CHUNKS*OFS_W-1:0] byte_d;
  logic [NUM_CHUNKS*BIT_W-1:0] bit_d;
  logic                        err_d;

  generate
    for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
      ecc_chunk_classify #(
        .PARITY_W   (PARITY_W),
        .CODE_BYTES (CODE_BYTES)
      ) i_cls (
        .stored_i (stored_ecc_i[c*RAW_W +: RAW_W]),
        .calc_i   (calc_ecc_i[c*RAW_W +: RAW_W]),
        .cls_o    (cls_w[c]),
        .loc_o    (loc_w[c])
      );
      if (c == 0) begin : g_base
        assign eff_w[c] = cls_w[c];
      end else begin : g_ext
        assign eff_w[c] = dual_i ? cls_w[c] : CLS_CLEAN;
      end
    end
  endgenerate

  always_comb begin
    err_d = 1'b0;
    for (int c = 0; c < NUM_CHUNKS; c++) begin
      status_d[2*c +: 2] = eff_w[c];
      fixv_d[c]          = (eff_w[c] == CLS_FIXABLE);
      byte_d[c*OFS_W +: OFS_W] = fixv_d[c] ?
          OFS_W'(c * CHUNK_BYTES) + OFS_W'(loc_w[c][PARITY_W-1:BIT_W]) : '0;
      bit_d[c*BIT_W +: BIT_W]  = fixv_d[c] ? loc_w[c][BIT_W-1:0] : '0;
      err_d = err_d | cls_is_err(eff_w[c]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      status_o    <= '0;
      fix_valid_o <= '0;
      fix_byte_o  <= '0;
      fix_bit_o   <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        err_o       <= err_d;
        status_o    <= status_d;
        fix_valid_o <= fixv_d;
        fix_byte_o  <= byte_d;
        fix_bit_o   <= bit_d;
      end
    end
  end

endmodule

// File: rtl/ecc_syndrome_checker_chk.sv
module ecc_syndrome_checker_chk #(
  parameter int NUM_CHUNKS  = 2,
  parameter int OFS_W       = 9,
  parameter int BIT_W       = 3,
  parameter int CHUNK_BYTES = 256
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        start_i,
  input logic                        dual_i,
  input logic                        done_o,
  input logic                        err_o,
  input logic [2*NUM_CHUNKS-1:0]     status_o,
  input logic [NUM_CHUNKS-1:0]       fix_valid_o,
  input logic [NUM_CHUNKS*OFS_W-1:0] fix_byte_o,
  input logic [NUM_CHUNKS*BIT_W-1:0] fix_bit_o
);

  logic any_err;
  always_comb begin
    any_err = 1'b0;
    for (int c = 0; c < NUM_CHUNKS; c++)
      any_err = any_err | (status_o[2*c +: 2] == 2'd1) | (status_o[2*c +: 2] == 2'd3);
  end

  assert_done_after_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  assert_done_pulse_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  assert_results_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(status_o) && $stable(err_o) && $stable(fix_valid_o)
                  && $stable(fix_byte_o) && $stable(fix_bit_o)));

  assert_err_merge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == any_err);

  generate
    for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chk
      assert_fix_means_fixable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fix_valid_o[c] |-> status_o[2*c +: 2] == 2'd2);
      if (c > 0) begin : g_ext
        assert_single_mode_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (start_i && !dual_i) |=> (status_o[2*c +: 2] == 2'd0 && !fix_valid_o[c]));
        assert_upper_offset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
          fix_valid_o[c] |-> fix_byte_o[c*OFS_W +: OFS_W] >= OFS_W'(c * CHUNK_BYTES));
      end
    end
  endgenerate

endmodule

bind ecc_syndrome_checker ecc_syndrome_checker_chk #(
  .NUM_CHUNKS  (NUM_CHUNKS),
  .OFS_W       (OFS_W),
  .BIT_W       (BIT_W),
  .CHUNK_BYTES (CHUNK_BYTES)
) i_chk (.*);

// File: tb/test_ecc_syndrome_checker.sv
module test_ecc_syndrome_checker;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dual = 1'b0;
  logic [47:0] stored = '0;
  logic [47:0] calc = '0;
  logic        done, err;
  logic [3:0]  status;
  logic [1:0]  fix_valid;
  logic [17:0] fix_byte;
  logic [5:0]  fix_bit;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [23:0] CALC0 = 24'h2B3C4D;
  localparam logic [23:0] CALC1 = 24'h15A7E1;

  always #(CLK_P / 2) clk = ~clk;

  ecc_syndrome_checker i_ecc_syndrome_checker (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .dual_i       (dual),
    .stored_ecc_i (stored),
    .calc_ecc_i   (calc),
    .done_o       (done),
    .err_o        (err),
    .status_o     (status),
    .fix_valid_o  (fix_valid),
    .fix_byte_o   (fix_byte),
    .fix_bit_o    (fix_bit)
  );

  // syndrome of a single data-bit flip at byte b, bit k
  function automatic logic [23:0] fix_syn(input logic [7:0] b, input logic [2:0] k);
    logic [10:0] l;
    l = {b, k};
    return {2'b00, ~l, l};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [23:0] st0, input logic [23:0] cl0,
                      input logic [23:0] st1, input logic [23:0] cl1, input logic d);
    @(negedge clk);
    stored = {st1, st0};
    calc   = {cl1, cl0};
    dual   = d;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset err", 32'(err), 0);
    chk("R1 reset status", 32'(status), 0);
    chk("R1 reset fix", 32'({fix_valid, fix_byte, fix_bit}), 0);
  endtask

  task automatic t_clean();
    fire(CALC0, CALC0, CALC1, CALC1, 1'b0);
    chk("R1 done strobe", 32'(done), 1);
    chk("R3 equal codes status", 32'(status), 0);
    chk("R3 equal codes err", 32'(err), 0);
    fire(24'h0, CALC0, CALC1, CALC1, 1'b0);
    chk("R3 stored zero", 32'({err, status}), 0);
    fire(CALC0, 24'h0, CALC1, CALC1, 1'b0);
    chk("R3 calc zero", 32'({err, status}), 0);
    @(negedge clk);
    chk("R1 done drops", 32'(done), 0);
  endtask

  task automatic t_field();
    fire(CALC0 ^ 24'h000400, CALC0, CALC1, CALC1, 1'b0);
    chk("R4 status", 32'(status), 32'h1);
    chk("R4 err", 32'(err), 1);
    chk("R4 no fix", 32'(fix_valid), 0);
  endtask

  task automatic t_fix();
    fire(CALC0 ^ fix_syn(8'hA5, 3'd3), CALC0, CALC1, CALC1, 1'b0);
    chk("R5 status", 32'(status), 32'h2);
    chk("R5 err", 32'(err), 0);
    chk("R5 fix valid", 32'(fix_valid), 32'h1);
    chk("R5 R8 byte", 32'(fix_byte[8:0]), 32'h0A5);
    chk("R5 R8 bit", 32'(fix_bit[2:0]), 3);
    fire(CALC0 ^ fix_syn(8'h00, 3'd0), CALC0, CALC1, CALC1, 1'b0);
    chk("R5 byte zero corner", 32'({status, fix_byte[8:0], fix_bit[2:0]}), 32'h2000);
  endtask

  task automatic t_fatal();
    fire(CALC0 ^ 24'h000003, CALC0, CALC1, CALC1, 1'b0);
    chk("R6 two-bit status", 32'(status), 32'h3);
    chk("R6 two-bit err", 32'(err), 1);
    fire(CALC0 ^ 24'h000BFF, CALC0, CALC1, CALC1, 1'b0);
    chk("R6 eleven not paired", 32'({err, status, fix_valid}), {27'd0, 1'b1, 4'h3} << 2);
  endtask

  task automatic t_pad();
    fire(CALC0 ^ 24'hC00000, CALC0, CALC1, CALC1, 1'b0);
    chk("R7 pad bits ignored", 32'({err, status}), 0);
    fire(24'h800000, CALC0, CALC1, CALC1, 1'b0);
    chk("R7 stored zero in low bits", 32'({err, status}), 0);
  endtask

  task automatic t_dual();
    fire(CALC0 ^ fix_syn(8'hA5, 3'd3), CALC0, CALC1 ^ 24'h000003, CALC1, 1'b1);
    chk("R9 mixed status", 32'(status), 32'hE);
    chk("R10 mixed err", 32'(err), 1);
    chk("R9 mixed fix valid", 32'(fix_valid), 32'h1);
    chk("R9 mixed byte0", 32'(fix_byte[8:0]), 32'h0A5);
    fire(CALC0, CALC0, CALC1 ^ fix_syn(8'h12, 3'd6), CALC1, 1'b1);
    chk("R9 upper status", 32'(status), 32'h8);
    chk("R10 upper err", 32'(err), 0);
    chk("R8 R9 upper byte", 32'(fix_byte[17:9]), 32'h112);
    chk("R8 upper bit", 32'(fix_bit[5:3]), 6);
  endtask

  task automatic t_single();
    fire(CALC0 ^ 24'h000400, CALC0, CALC1 ^ 24'h000003, CALC1, 1'b0);
    chk("R9 single mode status", 32'(status), 32'h1);
    chk("R10 single mode err", 32'(err), 1);
    fire(CALC0, CALC0, CALC1 ^ fix_syn(8'h12, 3'd6), CALC1, 1'b0);
    chk("R9 single mode no fix", 32'({err, status, fix_valid}), 0);
  endtask

  task automatic t_hold();
    fire(CALC0 ^ fix_syn(8'h3C, 3'd5), CALC0, CALC1, CALC1, 1'b0);
    stored = {CALC1 ^ 24'h3, CALC0 ^ 24'h7};
    dual = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 hold done", 32'(done), 0);
    chk("R2 hold status", 32'({err, status, fix_valid}), {27'd0, 1'b0, 4'h2, 2'b01});
    chk("R2 hold loc", 32'({fix_byte[8:0], fix_bit[2:0]}), {20'd0, 9'h03C, 3'd5});
  endtask

  task automatic t_b2b();
    @(negedge clk);
    stored = {CALC1, CALC0 ^ 24'h000400};
    calc = {CALC1, CALC0};
    dual = 1'b0;
    start = 1'b1;
    @(negedge clk);
    chk("R1 b2b first done", 32'(done), 1);
    chk("R1 b2b first status", 32'(status), 32'h1);
    stored = {CALC1, CALC0 ^ fix_syn(8'hA5, 3'd3)};
    @(negedge clk);
    start = 1'b0;
    chk("R1 b2b second done", 32'(done), 1);
    chk("R1 b2b second result", 32'({status, fix_byte[8:0]}), {19'd0, 4'h2, 9'h0A5});
    @(negedge clk);
    chk("R1 b2b strobe ends", 32'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_P * 2);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_clean();
    t_field();
    t_fix();
    t_fatal();
    t_pad();
    t_dual();
    t_single();
    t_hold();
    t_b2b();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule